// File: doc/BRIEF.md
# Per-Pin Edge and Level Event Detector

This block watches a bank of general-purpose input pins. Each pin carries a 4-bit mode code that decides what kind of pin activity counts as an event. Three codes turn an edge (rising, falling or either) into a DMA request. Five codes turn a level (low or high) or an edge (rising, falling or either) into an interrupt. When a pin's event occurs, a sticky flag for that pin is set. The flag stays set until software clears it by writing a one to it.

Software reaches the block through a simple 32-bit read/write register bus. There is one control word per pin, at byte offset 4*n. It holds the mode code and that pin's flag. A summary word at offset 0xA0 shows every flag at once, and can also clear them. The block combines the flags of the interrupt-mode pins into one interrupt line, and the flags of the DMA-mode pins into one DMA request line. Pin inputs are treated as asynchronous and are synchronized inside the block.

Top module: `pin_event_port`

## Requirements
- R1: After reset, every mode code and every flag is 0. `irq_o` and `dma_req_o` are low, and every register reads 0.
- R2: The control word of pin n is at byte offset 4*n. It stores the mode code in bits 19:16. All bits other than 19:16 and 24 read as 0. Read data appears on `rdata_o` one clock after the read request.
- R3: Mode code 0 never sets the pin's flag. The reserved codes 4 to 7 and 13 to 15 also never set it. A reserved code still reads back as it was written.
- R4: Codes 1, 2 and 3 set the flag on a rising, falling or either edge of the pin. Such a flag drives `dma_req_o` and not `irq_o`.
- R5: Codes 9, 10 and 11 set the flag on a rising, falling or either edge of the pin. Such a flag drives `irq_o` and not `dma_req_o`.
- R6: Code 8 sets the flag while the pin is low, and code 12 sets it while the pin is high. If the level still holds after a clear, the flag sets again on a following clock.
- R7: The pin flag is bit 24 of the control word. Writing a 1 to bit 24 clears the flag, and writing a 0 leaves it unchanged. So writing back the value just read clears a set flag.
- R8: The summary word at offset 0xA0 shows the flag of pin n in bit n. Writing it clears each flag whose bit is 1 and leaves the others unchanged.
- R9: `irq_o` is the OR of all flags of pins using codes 8 to 12. `dma_req_o` is the OR of all flags of pins using codes 1 to 3.
- R10: If an event is detected in the same clock as a clear write to that pin, the flag stays set.
- R11: A pin input passes through a two-flop synchronizer. Edges are found at the synchronizer output. If a pin changes before clock edge k, the flag is set by edge k+2 and is not set before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | NUM_PINS | Asynchronous pin inputs |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address within the port |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one clock after a read request |
| irq_o | output | 1 | Combined interrupt |
| dma_req_o | output | 1 | Combined DMA request |

## Verification
The assertions assume a bus write arrives as a request held for one clock. They also assume a pin holds each level long enough to pass the synchronizer before the flag is checked. The bench keeps within both assumptions. It drives every bus access and pin change at the falling clock edge, and it lets a pin settle for several clocks before it reads a flag. The random trials pick one pin and one mode code at a time and hold all other pins disabled. The bench's expected flag is therefore the level term of the mode at the old and new pin values, ORed with the edge term for the transition. The directed cases cover the exact latency and the clear that collides with an event in the same clock.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;
  localparam int MODE_LSB = 16;
  localparam int MODE_W   = 4;
  localparam int FLAG_BIT = 24;
  localparam int STATUS_OFFSET = 'hA0;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF      = 4'd0,
    MODE_DMA_RISE = 4'd1,
    MODE_DMA_FALL = 4'd2,
    MODE_DMA_ANY  = 4'd3,
    MODE_IRQ_LOW  = 4'd8,
    MODE_IRQ_RISE = 4'd9,
    MODE_IRQ_FALL = 4'd10,
    MODE_IRQ_ANY  = 4'd11,
    MODE_IRQ_HIGH = 4'd12
  } pin_mode_e;

  function automatic logic mode_is_dma(logic [MODE_W-1:0] m);
    return (m >= MODE_DMA_RISE) && (m <= MODE_DMA_ANY);
  endfunction

  function automatic logic mode_is_irq(logic [MODE_W-1:0] m);
    return (m >= MODE_IRQ_LOW) && (m <= MODE_IRQ_HIGH);
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/pin_detect.sv
module pin_detect
  import pin_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              clr_i,
  input  logic              pin_i,
  input  logic              pin_prev_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              flag_o,
  output logic              irq_flag_o,
  output logic              dma_flag_o
);
  logic [MODE_W-1:0] mode_q;
  logic              flag_q;
  logic              ev;
  logic              rise, fall;

  assign rise = pin_i & ~pin_prev_i;
  assign fall = ~pin_i & pin_prev_i;

  always_comb begin
    unique case (mode_q)
      MODE_DMA_RISE, MODE_IRQ_RISE: ev = rise;
      MODE_DMA_FALL, MODE_IRQ_FALL: ev = fall;
      MODE_DMA_ANY,  MODE_IRQ_ANY:  ev = rise | fall;
      MODE_IRQ_LOW:                 ev = ~pin_i;
      MODE_IRQ_HIGH:                ev = pin_i;
      default:                      ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (mode_we_i) mode_q <= mode_i;
      // new event beats a concurrent clear
      if (ev)         flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign mode_o     = mode_q;
  assign flag_o     = flag_q;
  assign irq_flag_o = flag_q & mode_is_irq(mode_q);
  assign dma_flag_o = flag_q & mode_is_dma(mode_q);

  p_event_sets_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev |=> flag_o);
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !ev) |=> !flag_o);
  p_off_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_is_irq(mode_o) && !mode_is_dma(mode_o) && !flag_o) |=> !flag_o);
endmodule

// File: rtl/pin_event_port.sv
module pin_event_port
  import pin_evt_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic                irq_o,
  output logic                dma_req_o
);
  localparam int IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int PCR_SPAN = NUM_PINS * 4;
  localparam logic [31:0] PCR_MASK = (32'(1) << FLAG_BIT) |
                                     (((32'(1) << MODE_W) - 1) << MODE_LSB);

  logic [NUM_PINS-1:0] pin_sync_w, pin_prev_w;
  logic [NUM_PINS-1:0] flags, irq_flags, dma_flags;
  logic [MODE_W-1:0]   modes [NUM_PINS];
  logic                pcr_hit, status_hit, wr, rd;
  logic [IDX_W-1:0]    idx;
  logic [31:0]         pcr_word, rdata_q;

  assign pcr_hit    = addr_i < ADDR_W'(PCR_SPAN);
  assign status_hit = addr_i == ADDR_W'(STATUS_OFFSET);
  assign idx        = addr_i[IDX_W+1:2];
  assign wr         = req_i & we_i;
  assign rd         = req_i & ~we_i;

  pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pins_i),
    .sync_o (pin_sync_w),
    .prev_o (pin_prev_w)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic sel, clr;
    assign sel = wr & pcr_hit & (idx == IDX_W'(i));
    assign clr = (sel & wdata_i[FLAG_BIT]) | (wr & status_hit & wdata_i[i]);

    pin_detect det_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_we_i (sel),
      .mode_i    (wdata_i[MODE_LSB +: MODE_W]),
      .clr_i     (clr),
      .pin_i     (pin_sync_w[i]),
      .pin_prev_i(pin_prev_w[i]),
      .mode_o    (modes[i]),
      .flag_o    (flags[i]),
      .irq_flag_o(irq_flags[i]),
      .dma_flag_o(dma_flags[i])
    );
  end

  always_comb begin
    pcr_word = '0;
    pcr_word[MODE_LSB +: MODE_W] = modes[idx];
    pcr_word[FLAG_BIT]           = flags[idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          rdata_q <= '0;
    else if (rd) begin
      if (pcr_hit)         rdata_q <= pcr_word;
      else if (status_hit) rdata_q <= 32'(flags);
      else                 rdata_q <= '0;
    end
  end

  assign rdata_o   = rdata_q;
  assign irq_o     = |irq_flags;
  assign dma_req_o = |dma_flags;

  p_irq_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|flags));
  p_dma_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (|flags));
  p_rd_unused_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && pcr_hit) |=> ((rdata_o & ~PCR_MASK) == 32'd0));
  p_status_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && status_hit) |=> (rdata_o == 32'($past(flags))));
endmodule

// File: tb/pin_event_port_tb_top.sv
`timescale 1ns/1ps
module pin_event_port_tb_top;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq, dma;
  int            n_tests = 0, n_fail = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  pin_event_port dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pins_i(pins), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .dma_req_o(dma)
  );

  function automatic logic lvl_hit(logic [3:0] m, logic v);
    return (m == 4'd8 && !v) || (m == 4'd12 && v);
  endfunction
  function automatic logic edge_hit(logic [3:0] m, logic o, logic v);
    logic r = !o && v, f = o && !v;
    case (m)
      4'd1, 4'd9:  return r;
      4'd2, 4'd10: return f;
      4'd3, 4'd11: return r | f;
      default:     return 1'b0;
    endcase
  endfunction
  function automatic logic is_irq(logic [3:0] m); return m >= 4'd8 && m <= 4'd12; endfunction
  function automatic logic is_dma(logic [3:0] m); return m >= 4'd1 && m <= 4'd3; endfunction
  function automatic logic [31:0] pcr(logic [3:0] m, logic f);
    return (32'(f) << 24) | (32'(m) << 16);
  endfunction

  task automatic check(string req_tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_0042));
    idle(3); rst_ni = 1'b1; idle(2);

    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 dma", 32'(dma), 0);
    bus_rd(12'h000, d); check("R1 pcr0", d, 0);
    bus_rd(12'h07C, d); check("R1 pcr31", d, 0);
    bus_rd(12'h0A0, d); check("R1 status", d, 0);

    // R2/R3 storage, unused bits, reserved code readback
    bus_wr(12'h014, 32'hFFFF_FFFF);
    bus_rd(12'h014, d); check("R2 pcr5 mask", d, pcr(4'hF, 0));
    bus_wr(12'h07C, pcr(4'd10, 0));
    bus_rd(12'h07C, d); check("R2 pcr31 mode", d, pcr(4'd10, 0));
    pins[5] = 1'b1; idle(5);
    bus_rd(12'h014, d); check("R3 reserved no flag", d, pcr(4'hF, 0));
    pins[5] = 1'b0; idle(5);
    bus_wr(12'h014, 0); bus_wr(12'h07C, 0);

    // R11 latency on pin 3, rising interrupt
    bus_wr(12'h00C, pcr(4'd9, 0)); idle(3);
    @(negedge clk); pins[3] = 1'b1;
    @(negedge clk); check("R11 not after 1 edge", 32'(irq), 0);
    @(negedge clk); check("R11 not after 2 edges", 32'(irq), 0);
    @(negedge clk); check("R11 set after 3 edges", 32'(irq), 1);
    check("R5 rise irq no dma", 32'(dma), 0);

    // R7 write-zero keeps, readback-writeback clears
    bus_wr(12'h00C, pcr(4'd9, 0));
    bus_rd(12'h00C, d); check("R7 zero keeps flag", d, pcr(4'd9, 1));
    bus_wr(12'h00C, d);
    bus_rd(12'h00C, d); check("R7 writeback clears", d, pcr(4'd9, 0));

    // R8 summary view and clear
    pins[3] = 1'b0; idle(4); pins[3] = 1'b1; idle(4);
    bus_rd(12'h0A0, d); check("R8 status bit3", d, 32'h8);
    bus_wr(12'h0A0, 32'hFFFF_FFF7);
    bus_rd(12'h0A0, d); check("R8 zero bit keeps", d, 32'h8);
    bus_wr(12'h0A0, 32'h8);
    bus_rd(12'h0A0, d); check("R8 one bit clears", d, 0);
    check("R9 irq low after clear", 32'(irq), 0);

    // R10 event collides with clear
    bus_wr(12'h00C, pcr(4'd11, 0));
    @(negedge clk); pins[3] = 1'b0;
    @(negedge clk);
    bus_wr(12'h00C, pcr(4'd11, 1));
    bus_rd(12'h00C, d); check("R10 event beats clear", d, pcr(4'd11, 1));
    bus_wr(12'h00C, pcr(4'd11, 1));
    bus_rd(12'h00C, d); check("R10 plain clear", d, pcr(4'd11, 0));
    bus_wr(12'h00C, 0);

    // R6 level re-assert
    pins[7] = 1'b1; idle(4);
    bus_wr(12'h01C, pcr(4'd12, 0)); idle(4);
    bus_wr(12'h0A0, 32'h80); idle(3);
    bus_rd(12'h0A0, d); check("R6 high re-asserts", d, 32'h80);
    pins[7] = 1'b0; idle(4);
    bus_wr(12'h0A0, 32'h80); idle(3);
    bus_rd(12'h0A0, d); check("R6 stays clear once low", d, 0);
    bus_wr(12'h01C, pcr(4'd8, 0)); idle(3);
    check("R6 low level irq", 32'(irq), 1);
    bus_wr(12'h01C, pcr(4'd0, 1));

    // random trials: R3 R4 R5 R6 R9
    for (int t = 0; t < 64; t++) begin
      int unsigned p = $urandom_range(NP - 1);
      logic [3:0] m = (t < 16) ? 4'(t) : 4'($urandom_range(15));
      logic o = 1'($urandom_range(1));
      logic v = 1'($urandom_range(1));
      logic ef;
      logic [11:0] a = 12'(p * 4);
      bus_wr(a, 0); bus_wr(12'h0A0, 32'hFFFF_FFFF);
      pins[p] = o; idle(4);
      bus_wr(a, pcr(m, 0)); idle(1);
      bus_wr(a, pcr(m, 1)); idle(3);
      pins[p] = v; idle(5);
      ef = lvl_hit(m, o) | lvl_hit(m, v) | edge_hit(m, o, v);
      bus_rd(a, d);
      check($sformatf("R3/R4/R5/R6 mode %0d pin %0d %b->%b", m, p, o, v), d, pcr(m, ef));
      check("R9 irq", 32'(irq), 32'(ef & is_irq(m)));
      check("R9 dma", 32'(dma), 32'(ef & is_dma(m)));
      bus_wr(a, pcr(4'd0, 1));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule